// File: doc/BRIEF.md
# Extension Immediate Builder

This block sits beside the decode stage of a processor whose instructions are a fixed 16 bits wide. Such short words leave little room for constants. A long constant is therefore built up over a run of prefix instructions, and each prefix contributes a 14-bit slice. The block holds the partial value in a 32-bit accumulation register, together with a sticky flag that records whether the previous valid instruction was a prefix.

The first prefix after the flag has cleared loads its slice sign-extended. Each further prefix shifts the register up by one slice and appends its own 14 bits. An instruction that consumes a short immediate offers its field, which is 3 or 4 bits wide. With the flag clear, the field alone becomes a sign-extended operand. With the flag set, the field is appended below the accumulated value. Any valid instruction that is not a prefix clears the flag, so a partly built constant never reaches a later, unrelated instruction.

Top module: `ext_imm_builder`

## Requirements
- R1: A synchronous active-high reset clears the accumulation register to zero and clears the flag. Reset takes precedence over a valid prefix presented in the same cycle.
- R2: An instruction is a prefix only when bits 15:14 equal 2'b01. Its constant is bits 13:0. The tags 2'b00, 2'b10 and 2'b11 are not prefixes.
- R3: A valid prefix that arrives with the flag clear loads the register with its 14-bit constant sign-extended to 32 bits.
- R4: A valid prefix that arrives with the flag set loads the register with the old value shifted left by 14, with the new constant in bits 13:0. Bits shifted out above bit 31 are lost.
- R5: A valid prefix sets the flag at the next clock edge.
- R6: A valid consuming non-prefix instruction with the flag clear yields an operand equal to its short field sign-extended to 32 bits. The field is immField[3:0] when immWide is 1, and immField[2:0] when immWide is 0.
- R7: A valid consuming non-prefix instruction with the flag set yields an operand equal to the register shifted left by the field width (4 or 3), OR'd with the field zero-extended.
- R8: Any valid non-prefix instruction, whether it consumes or not, clears the flag and leaves the register unchanged.
- R9: While instrValid is low, neither the register nor the flag changes.
- R10: The operand output is zero in any cycle without a valid consuming non-prefix instruction. This includes a prefix presented with useImm high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 16 | Instruction word from decode |
| useImm | input | 1 | The instruction consumes a short immediate |
| immField | input | 4 | Short immediate field of the consumer |
| immWide | input | 1 | 1: field is 4 bits wide, 0: field is the low 3 bits |
| operand | output | 32 | Built operand, combinational from state and inputs |
| extFlag | output | 1 | Extension flag |
| extReg | output | 32 | Accumulation register value |

## Verification
The operand is combinational: it is due in the same cycle that a consuming instruction is presented. The bench samples it one nanosecond after driving the inputs on the falling edge, which is before the next rising edge. The register and the flag are due one rising edge after the instruction, so the bench checks them one nanosecond after that edge. A reference model in the bench updates at the same edge, using multiplication and modular arithmetic rather than bit slicing. The bench sweeps every short field value at both widths with the flag clear and with the flag set. It also runs chains of one to three prefixes with negative slices, chains broken by unrelated instructions, and idle cycles.

// File: rtl/ext_imm_pkg.sv
package ext_imm_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadNew;    // first prefix: sign-extended load
    logic shiftAcc;   // chained prefix: shift and append
    logic consumeNow; // valid consuming non-prefix instruction
  } ctrlStrobes_t;
endpackage

// File: rtl/ext_imm_ctrl.sv
module ext_imm_ctrl
  import ext_imm_pkg::*;
#(
  parameter int TAG_W = 2,
  parameter logic [TAG_W-1:0] PREFIX_TAG = 2'b01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instrValid,
  input  logic [TAG_W-1:0] instrTag,
  input  logic             useImm,
  output ctrlStrobes_t     strobes,
  output logic             extFlag
);
  logic isPrefix;
  logic flagQ;

  assign isPrefix = (instrTag == PREFIX_TAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      flagQ <= 1'b0;
    end else if (instrValid) begin
      flagQ <= isPrefix;
    end
  end

  always_comb begin
    strobes.loadNew    = instrValid && isPrefix && !flagQ;
    strobes.shiftAcc   = instrValid && isPrefix && flagQ;
    strobes.consumeNow = instrValid && !isPrefix && useImm;
  end

  assign extFlag = flagQ;
endmodule

// File: rtl/ext_imm_datapath.sv
module ext_imm_datapath
  import ext_imm_pkg::*;
#(
  parameter int CONST_W  = 14,
  parameter int EXT_W    = 32,
  parameter int NARROW_W = 3,
  parameter int WIDE_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  input  logic               extFlag,
  input  logic [CONST_W-1:0] prefixConst,
  input  logic [WIDE_W-1:0]  immField,
  input  logic               immWide,
  output logic [EXT_W-1:0]   extReg,
  output logic [EXT_W-1:0]   operand
);
  localparam int PAD_W = EXT_W - CONST_W;

  logic [EXT_W-1:0] accQ;
  logic [EXT_W-1:0] firstLoad;
  logic [EXT_W-1:0] chainLoad;
  logic [EXT_W-1:0] narrowSext, wideSext, narrowCat, wideCat;
  logic [EXT_W-1:0] formed;

  assign firstLoad = {{PAD_W{prefixConst[CONST_W-1]}}, prefixConst};

  // The shift variant depends on whether a slice fills the register
  generate
    if (CONST_W < EXT_W) begin : g_shift
      assign chainLoad = {accQ[EXT_W-CONST_W-1:0], prefixConst};
    end else begin : g_replace
      assign chainLoad = prefixConst[EXT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ <= '0;
    end else if (strobes.loadNew) begin
      accQ <= firstLoad;
    end else if (strobes.shiftAcc) begin
      accQ <= chainLoad;
    end
  end

  assign narrowSext = {{(EXT_W-NARROW_W){immField[NARROW_W-1]}}, immField[NARROW_W-1:0]};
  assign wideSext   = {{(EXT_W-WIDE_W){immField[WIDE_W-1]}}, immField};
  assign narrowCat  = (accQ << NARROW_W) | {{(EXT_W-NARROW_W){1'b0}}, immField[NARROW_W-1:0]};
  assign wideCat    = (accQ << WIDE_W) | {{(EXT_W-WIDE_W){1'b0}}, immField};

  always_comb begin
    case ({extFlag, immWide})
      2'b00:   formed = narrowSext;
      2'b01:   formed = wideSext;
      2'b10:   formed = narrowCat;
      default: formed = wideCat;
    endcase
    operand = strobes.consumeNow ? formed : '0;
  end

  assign extReg = accQ;
endmodule

// File: rtl/ext_imm_builder.sv
module ext_imm_builder
  import ext_imm_pkg::*;
#(
  parameter int INSTR_W  = 16,
  parameter int TAG_W    = 2,
  parameter int EXT_W    = 32,
  parameter int NARROW_W = 3,
  parameter int WIDE_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               useImm,
  input  logic [WIDE_W-1:0]  immField,
  input  logic               immWide,
  output logic [EXT_W-1:0]   operand,
  output logic               extFlag,
  output logic [EXT_W-1:0]   extReg
);
  localparam int CONST_W = INSTR_W - TAG_W;

  ctrlStrobes_t strobes;

  ext_imm_ctrl #(
    .TAG_W(TAG_W),
    .PREFIX_TAG(TAG_W'(1))
  ) u_ctrl (
    .clk(clk),
    .rst(rst),
    .instrValid(instrValid),
    .instrTag(instrWord[INSTR_W-1:CONST_W]),
    .useImm(useImm),
    .strobes(strobes),
    .extFlag(extFlag)
  );

  ext_imm_datapath #(
    .CONST_W(CONST_W),
    .EXT_W(EXT_W),
    .NARROW_W(NARROW_W),
    .WIDE_W(WIDE_W)
  ) u_dp (
    .clk(clk),
    .rst(rst),
    .strobes(strobes),
    .extFlag(extFlag),
    .prefixConst(instrWord[CONST_W-1:0]),
    .immField(immField),
    .immWide(immWide),
    .extReg(extReg),
    .operand(operand)
  );
endmodule

// File: rtl/ext_imm_builder_chk.sv
module ext_imm_builder_chk #(
  parameter int INSTR_W = 16,
  parameter int TAG_W   = 2,
  parameter int EXT_W   = 32,
  parameter int WIDE_W  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               instrValid,
  input logic [INSTR_W-1:0] instrWord,
  input logic               useImm,
  input logic [EXT_W-1:0]   operand,
  input logic               extFlag,
  input logic [EXT_W-1:0]   extReg
);
  localparam int CONST_W = INSTR_W - TAG_W;
  localparam int UPPER_N = EXT_W - WIDE_W + 1;

  logic isPre;
  assign isPre = (instrWord[INSTR_W-1:CONST_W] == TAG_W'(1));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !instrValid |=> ($stable(extReg) && $stable(extFlag)));

  p_prefix_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (instrValid && isPre) |=> extFlag);

  p_nonprefix_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (instrValid && !isPre) |=> (!extFlag && $stable(extReg)));

  p_first_load_r3: assert property (@(posedge clk) disable iff (rst)
    (instrValid && isPre && !extFlag) |=>
      ($signed(extReg) == $signed($past(instrWord[CONST_W-1:0]))));

  p_chain_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (instrValid && isPre && extFlag) |=>
      (extReg[CONST_W-1:0] == $past(instrWord[CONST_W-1:0]) &&
       extReg[EXT_W-1:CONST_W] == $past(extReg[EXT_W-CONST_W-1:0])));

  p_quiet_operand_r10: assert property (@(posedge clk) disable iff (rst)
    !(instrValid && useImm && !isPre) |-> (operand == '0));

  p_short_sext_r6: assert property (@(posedge clk) disable iff (rst)
    (instrValid && useImm && !isPre && !extFlag) |->
      ($countones(operand[EXT_W-1:WIDE_W-1]) == 0 ||
       $countones(operand[EXT_W-1:WIDE_W-1]) == UPPER_N));
endmodule

bind ext_imm_builder ext_imm_builder_chk #(
  .INSTR_W(INSTR_W),
  .TAG_W(TAG_W),
  .EXT_W(EXT_W),
  .WIDE_W(WIDE_W)
) u_chk (
  .clk(clk),
  .rst(rst),
  .instrValid(instrValid),
  .instrWord(instrWord),
  .useImm(useImm),
  .operand(operand),
  .extFlag(extFlag),
  .extReg(extReg)
);

// File: tb/ext_imm_builder_bench.sv
module ext_imm_builder_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        instrValid;
  logic [15:0] instrWord;
  logic        useImm;
  logic [3:0]  immField;
  logic        immWide;
  logic [31:0] operand;
  logic        extFlag;
  logic [31:0] extReg;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] mReg;
  logic        mFlag;

  always #2 clk = ~clk;

  ext_imm_builder u_ext_imm_builder (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .useImm(useImm), .immField(immField), .immWide(immWide),
    .operand(operand), .extFlag(extFlag), .extReg(extReg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sextN(input int v, input int w);
    logic [31:0] r;
    r = 32'(v);
    if (v >= (1 << (w - 1))) r = r - 32'(1 << w);
    return r;
  endfunction

  function automatic logic [15:0] pre(input int k);
    return 16'h4000 | 16'(k & 16'h3FFF);
  endfunction

  task automatic step(input logic v, input logic [15:0] ins, input logic u,
                      input logic [3:0] f, input logic wd, input string req);
    logic isPre;
    logic [31:0] expOp;
    int w, fv;
    @(negedge clk);
    instrValid = v; instrWord = ins; useImm = u; immField = f; immWide = wd;
    #1;
    isPre = (ins[15:14] == 2'b01);
    expOp = 32'd0;
    if (v && u && !isPre) begin
      w  = wd ? 4 : 3;
      fv = wd ? int'(f) : int'(f) % 8;
      expOp = mFlag ? (mReg * 32'(1 << w)) + 32'(fv) : sextN(fv, w);
    end
    chk({req, " operand"}, operand, expOp);
    @(posedge clk);
    #1;
    if (v) begin
      if (isPre) begin
        mReg  = mFlag ? (mReg * 32'd16384) + 32'(ins[13:0]) : sextN(int'(ins[13:0]), 14);
        mFlag = 1'b1;
      end else begin
        mFlag = 1'b0;
      end
    end
    chk({req, " register"}, extReg, mReg);
    chk({req, " flag"}, 32'(extFlag), 32'(mFlag));
  endtask

  initial begin
    #(4 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    rst = 1'b1; instrValid = 1'b1; instrWord = pre(14'h1ABC);
    useImm = 1'b0; immField = 4'd0; immWide = 1'b0;
    mReg = 32'd0; mFlag = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 register", extReg, 32'd0);
    chk("R1 flag", 32'(extFlag), 32'd0);
    @(negedge clk); rst = 1'b0; instrValid = 1'b0;

    // R6: every short field at both widths with the flag clear
    for (int wd = 0; wd < 2; wd++)
      for (int f = 0; f < 16; f++)
        step(1'b1, 16'h0123, 1'b1, 4'(f), 1'(wd), "R6");

    // R7: every short field at both widths after one prefix (positive, then negative)
    for (int wd = 0; wd < 2; wd++)
      for (int f = 0; f < 16; f++) begin
        step(1'b1, pre(14'h0A5B), 1'b0, 4'd0, 1'b0, "R3");
        step(1'b1, 16'h0000, 1'b1, 4'(f), 1'(wd), "R7");
        step(1'b1, pre(14'h3FFE), 1'b1, 4'd0, 1'b0, "R5");
        step(1'b1, 16'hF000, 1'b1, 4'(f), 1'(wd), "R7");
      end

    // R4: chains of one to three prefixes
    for (int n = 1; n <= 3; n++) begin
      step(1'b1, pre(14'h1234), 1'b0, 4'd0, 1'b0, "R3");
      if (n > 1) step(1'b1, pre(14'h3ABC), 1'b0, 4'd0, 1'b0, "R4");
      if (n > 2) step(1'b1, pre(14'h3F0F), 1'b0, 4'd0, 1'b0, "R4");
      step(1'b1, 16'h2000, 1'b1, 4'hB, 1'b1, "R4");
      step(1'b1, pre(14'h2000), 1'b0, 4'd0, 1'b0, "R3");
      if (n > 1) step(1'b1, pre(14'h0001), 1'b0, 4'd0, 1'b0, "R4");
      if (n > 2) step(1'b1, pre(14'h3FFF), 1'b0, 4'd0, 1'b0, "R4");
      step(1'b1, 16'h1111, 1'b1, 4'h5, 1'b0, "R4");
    end

    // R2: the other tag codes are not prefixes
    step(1'b1, pre(14'h0777), 1'b0, 4'd0, 1'b0, "R3");
    step(1'b1, 16'h8777, 1'b0, 4'd0, 1'b0, "R2");
    step(1'b1, pre(14'h0777), 1'b0, 4'd0, 1'b0, "R3");
    step(1'b1, 16'hC777, 1'b0, 4'd0, 1'b0, "R2");
    step(1'b1, 16'h0777, 1'b1, 4'h7, 1'b1, "R2");

    // R8: a chain broken by an unrelated instruction restarts
    step(1'b1, pre(14'h2222), 1'b0, 4'd0, 1'b0, "R3");
    step(1'b1, 16'h3456, 1'b0, 4'h9, 1'b1, "R8");
    step(1'b1, pre(14'h0333), 1'b0, 4'd0, 1'b0, "R8");
    step(1'b1, 16'h0000, 1'b1, 4'h9, 1'b1, "R8");

    // R9: idle cycles leave the state alone, mid-chain
    step(1'b1, pre(14'h1555), 1'b0, 4'd0, 1'b0, "R3");
    step(1'b0, pre(14'h3AAA), 1'b1, 4'hF, 1'b1, "R9");
    step(1'b0, 16'h0000, 1'b1, 4'h3, 1'b1, "R9");
    step(1'b1, 16'h0000, 1'b1, 4'h6, 1'b1, "R9");

    // R10: a prefix with useImm high yields no operand
    step(1'b1, pre(14'h0042), 1'b1, 4'hA, 1'b1, "R10");
    step(1'b1, pre(14'h0043), 1'b1, 4'hA, 1'b0, "R10");
    step(1'b1, 16'h0000, 1'b0, 4'hA, 1'b1, "R10");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule